// File: doc/BRIEF.md
# External Data Bus Stretch Sequencer

This block runs one external data-memory access for an 8051-style core on a multiplexed bus. Address bits and data share a single byte-wide bus. The low address byte goes out first, and an address-latch strobe marks it so that an outside latch can capture it. The bus then either carries write data or is released so that memory can drive read data. The high address byte stays on its own port for the whole access.

A 3-bit stretch code, sampled when the access starts, lengthens the access. It sets how long the read or write strobe stays active. It also inserts fixed setup and hold extensions around the strobe. These extensions grow in steps, and there is a clear jump between codes 3 and 4, so slow peripherals get extra address setup and data setup time.

The core raises `start` for one clock with the direction, address, write data and code. When the access finishes, `done` pulses for one clock and `rd_data` holds the captured byte. Every output comes from a register.

Top module: `xbus_stretch_seq`

## Requirements
- R1: After reset, and whenever no access is running, `ale` is 0, `rd_n` and `wr_n` are 1, `bus_oe` is 0, `addr_hi` is 0 and `done` is 0.
- R2: An accepted start raises `ale` for exactly one clock, in the clock after the start edge. In that clock `bus_oe` is 1 and `bus_out` carries `addr[7:0]`. `addr_hi` carries `addr[15:8]` from the ALE clock through the last clock of the access.
- R3: After `ale` falls, `bus_out` keeps the low address byte with `bus_oe` = 1 for 1 + A clocks. A is 0 for code 0, 1 for codes 1 to 3, and 5 for codes 4 to 7.
- R4: A data-setup period of B clocks follows, with both strobes inactive. B is 0 for codes 0 to 3 and 4 for codes 4 to 7. During it, a write drives `wdata` on `bus_out` with `bus_oe` = 1, and a read has `bus_oe` = 0.
- R5: The strobe (`rd_n` for a read, `wr_n` for a write) is low for 2 + W consecutive clocks. W is 0 for code 0 and 4·code − 2 for codes 1 to 7.
- R6: A hold period of H1 + H2 clocks follows the strobe. H1 is 0 for code 0 and 1 otherwise. H2 is 0 for codes 0 to 2 and 1 for codes 3 to 7. During it, a write keeps `wdata` driven and a read keeps the bus released.
- R7: `done` is a one-clock pulse in the clock after the last access clock. From the rise of `ale` to the rise of `done`, an access takes 4, 8, 12, 17, 29, 33, 37 or 41 clocks for codes 0 to 7.
- R8: A read loads `rd_data` with `bus_in` as sampled at the edge that ends the last low clock of `rd_n`. `rd_data` then holds its value through later writes, until the next read.
- R9: While `rd_n` is low, `bus_oe` is 0. While `wr_n` is low, `bus_oe` is 1 and `bus_out` equals the write data.
- R10: A start pulse that arrives while an access is running is ignored. No second access follows it.
- R11: `stretch`, `addr`, `wdata` and `is_write` are sampled only at an accepted start. Changing them during the access has no effect on it.
- R12: At most one strobe is low at any time, and neither strobe is low while `ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock request to begin an access |
| is_write | input | 1 | 1 = write access, 0 = read access |
| addr | input | 16 | Full access address |
| wdata | input | 8 | Byte to write |
| stretch | input | 3 | Stretch code 0 to 7 |
| bus_in | input | 8 | Value read from the shared bus |
| ale | output | 1 | Address-latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_out | output | 8 | Value driven onto the shared bus |
| bus_oe | output | 1 | Shared-bus drive enable |
| addr_hi | output | 8 | High address byte port |
| rd_data | output | 8 | Byte captured by the last read |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
A wrong phase state or a wrong counter load shows up as a strobe, gap or hold that is too long or too short. The bench measures every segment in clocks, so an error of one clock in any code is reported when that access ends. A wrong direction latch shows up as the wrong strobe, or as the bus driven while `rd_n` is low, and the bench sees it in the first clock of the strobe. A capture at the wrong edge returns a neighbouring byte, because `bus_in` changes every strobe clock, and this appears in `rd_data` at the `done` pulse.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int CODE_W   = 3;
  // longest single span: strobe of the highest code
  localparam int MAX_SPAN = 2 + 4 * ((1 << CODE_W) - 1) - 2;
  localparam int CNT_W    = $clog2(MAX_SPAN + 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALE,
    PH_AHOLD,
    PH_DSETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  // length in clocks of each phase after ALE
  typedef struct packed {
    logic [CNT_W-1:0] ahold;
    logic [CNT_W-1:0] dsetup;
    logic [CNT_W-1:0] strobe;
    logic [CNT_W-1:0] hold;
  } span_t;
endpackage

// File: rtl/xbus_timing.sv
module xbus_timing
  import xbus_pkg::*;
#(
  parameter int AHOLD_BASE  = 1,
  parameter int SETUP_SHORT = 1,
  parameter int SETUP_LONG  = 5,
  parameter int LONG_CODE   = 4,
  parameter int DSETUP_LONG = 4,
  parameter int STROBE_BASE = 2,
  parameter int WIDTH_STEP  = 4,
  parameter int WIDTH_OFS   = 2,
  parameter int HOLD_ADDR   = 1,
  parameter int HOLD_DATA   = 1,
  parameter int WHOLD_CODE  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  output span_t             span
);
  span_t span_d;
  int    code_i;

  always_comb begin
    code_i = int'(code);
    span_d.ahold  = CNT_W'(AHOLD_BASE + ((code_i == 0) ? 0 :
                    ((code_i < LONG_CODE) ? SETUP_SHORT : SETUP_LONG)));
    span_d.dsetup = CNT_W'((code_i >= LONG_CODE) ? DSETUP_LONG : 0);
    span_d.strobe = CNT_W'(STROBE_BASE + ((code_i == 0) ? 0 :
                    (WIDTH_STEP * code_i - WIDTH_OFS)));
    span_d.hold   = CNT_W'(((code_i == 0) ? 0 : HOLD_ADDR) +
                    ((code_i >= WHOLD_CODE) ? HOLD_DATA : 0));
  end

  // the decoded spans change only at an accepted start
  always_ff @(posedge clk) begin
    if (rst) begin
      span <= '0;
    end else if (load) begin
      span <= span_d;
    end
  end
endmodule

// File: rtl/xbus_phase_ctrl.sv
module xbus_phase_ctrl
  import xbus_pkg::*;
#(
  parameter int ALE_LEN = 1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  span_t  span,
  output phase_e ph_q,
  output phase_e ph_d,
  output logic   accept,
  output logic   stb_last,
  output logic   done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;
  logic             fin;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    accept = 1'b0;
    fin    = 1'b0;
    last   = (cnt_q == '0);
    if (ph_q != PH_IDLE && !last) begin
      cnt_d = cnt_q - CNT_W'(1);
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (start) begin
            accept = 1'b1;
            ph_d   = PH_ALE;
            cnt_d  = CNT_W'(ALE_LEN - 1);
          end
        end
        PH_ALE: begin
          ph_d  = PH_AHOLD;
          cnt_d = span.ahold - CNT_W'(1);
        end
        PH_AHOLD: begin
          if (span.dsetup != '0) begin
            ph_d  = PH_DSETUP;
            cnt_d = span.dsetup - CNT_W'(1);
          end else begin
            ph_d  = PH_STROBE;
            cnt_d = span.strobe - CNT_W'(1);
          end
        end
        PH_DSETUP: begin
          ph_d  = PH_STROBE;
          cnt_d = span.strobe - CNT_W'(1);
        end
        PH_STROBE: begin
          if (span.hold != '0) begin
            ph_d  = PH_HOLD;
            cnt_d = span.hold - CNT_W'(1);
          end else begin
            ph_d = PH_IDLE;
            fin  = 1'b1;
          end
        end
        PH_HOLD: begin
          ph_d = PH_IDLE;
          fin  = 1'b1;
        end
        default: begin
          ph_d = PH_IDLE;
        end
      endcase
    end
  end

  assign stb_last = (ph_q == PH_STROBE) && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      done  <= fin;
    end
  end

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_IDLE) |=> (ph_q != PH_ALE));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_after_access_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(ph_q) == PH_STROBE || $past(ph_q) == PH_HOLD));

  // R11
  span_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_IDLE && ph_q != PH_ALE) |-> $stable(span));
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     accept,
  input  phase_e                   ph_d,
  input  logic                     stb_last,
  input  logic                     is_write,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W-1:0]        bus_in,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        bus_out,
  output logic                     bus_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        rd_data
);
  logic              wr_q, wr_c;
  logic [ADDR_W-1:0] addr_q, addr_c;
  logic [DATA_W-1:0] wdata_q, wdata_c;

  // request fields are taken from the ports only at the accepting edge
  assign wr_c    = accept ? is_write : wr_q;
  assign addr_c  = accept ? addr     : addr_q;
  assign wdata_c = accept ? wdata    : wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= is_write;
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale     <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      bus_out <= '0;
      bus_oe  <= 1'b0;
      addr_hi <= '0;
      rd_data <= '0;
    end else begin
      ale     <= (ph_d == PH_ALE);
      rd_n    <= !((ph_d == PH_STROBE) && !wr_c);
      wr_n    <= !((ph_d == PH_STROBE) && wr_c);
      addr_hi <= (ph_d == PH_IDLE) ? '0 : addr_c[ADDR_W-1:DATA_W];
      unique case (ph_d)
        PH_ALE, PH_AHOLD: begin
          bus_oe  <= 1'b1;
          bus_out <= addr_c[DATA_W-1:0];
        end
        PH_DSETUP, PH_STROBE, PH_HOLD: begin
          bus_oe  <= wr_c;
          bus_out <= wr_c ? wdata_c : '0;
        end
        default: begin
          bus_oe  <= 1'b0;
          bus_out <= '0;
        end
      endcase
      if (stb_last && !wr_q) begin
        rd_data <= bus_in;
      end
    end
  end

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !((!rd_n && !wr_n) || (ale && (!rd_n || !wr_n))));

  // R9
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !bus_oe);

  // R9
  wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> bus_oe);

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  // R2
  ale_addr_chk: assert property (@(posedge clk) disable iff (rst)
    ale |-> bus_oe);
endmodule

// File: rtl/xbus_stretch_seq.sv
module xbus_stretch_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     is_write,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [CODE_W-1:0]        stretch,
  input  logic [DATA_W-1:0]        bus_in,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        bus_out,
  output logic                     bus_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     done
);
  span_t  span;
  phase_e ph_q, ph_d;
  logic   accept;
  logic   stb_last;

  xbus_timing u_timing (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .code (stretch),
    .span (span)
  );

  xbus_phase_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .span     (span),
    .ph_q     (ph_q),
    .ph_d     (ph_d),
    .accept   (accept),
    .stb_last (stb_last),
    .done     (done)
  );

  xbus_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .ph_d     (ph_d),
    .stb_last (stb_last),
    .is_write (is_write),
    .addr     (addr),
    .wdata    (wdata),
    .bus_in   (bus_in),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe),
    .addr_hi  (addr_hi),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/xbus_stretch_seq_bench.sv
module xbus_stretch_seq_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        is_write = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [2:0]  stretch = '0;
  logic [7:0]  bus_in = '0;
  logic        ale, rd_n, wr_n, bus_oe, done;
  logic [7:0]  bus_out, addr_hi, rd_data;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  seed;
    logic [7:0]  n_addr;
    logic [7:0]  n_pre;
    logic [7:0]  n_stb;
    logic [7:0]  n_post;
    logic [7:0]  total;
    logic [7:0]  rdx;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk = ~clk;

  xbus_stretch_seq u_xbus_stretch_seq (
    .clk(clk), .rst(rst), .start(start), .is_write(is_write), .addr(addr),
    .wdata(wdata), .stretch(stretch), .bus_in(bus_in), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .bus_out(bus_out), .bus_oe(bus_oe), .addr_hi(addr_hi),
    .rd_data(rd_data), .done(done)
  );

  task automatic check(input string req, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // driver: pushes the expected profile, then issues the request
  task automatic run_access(input logic wr, input int code, input logic [15:0] a,
                            input logic [7:0] d, input logic [7:0] seed, input bit inject);
    exp_t e;
    int ea, eb, w, ha, hd;
    ea = (code == 0) ? 0 : ((code < 4) ? 1 : 5);   // R3
    eb = (code < 4) ? 0 : 4;                        // R4
    w  = (code == 0) ? 0 : 4 * code - 2;            // R5
    ha = (code == 0) ? 0 : 1;                       // R6
    hd = (code < 3) ? 0 : 1;                        // R6
    e.wr     = wr;
    e.addr   = a;
    e.wdata  = d;
    e.seed   = seed;
    e.n_addr = 8'(1 + ea);
    e.n_pre  = 8'(eb);
    e.n_stb  = 8'(2 + w);
    e.n_post = 8'(ha + hd);
    e.total  = 8'(1 + 1 + ea + eb + 2 + w + ha + hd);
    e.rdx    = seed + 8'(2 + w - 1);
    sb_q.push_back(e);
    @(negedge clk);
    start = 1'b1; is_write = wr; addr = a; wdata = d; stretch = 3'(code);
    @(negedge clk);
    start = 1'b0;
    // R11: scramble request fields during the access
    is_write = ~wr; addr = ~a; wdata = ~d; stretch = ~3'(code);
    if (inject) begin
      // R10: start while busy
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    do @(negedge clk); while (!done);
    repeat (3) @(negedge clk);
  endtask

  // monitor: measures each access and compares it with the queued profile
  initial begin
    exp_t cur;
    bit   in_acc = 0;
    bit   seen_stb = 0;
    int   n_ale = 0, n_addr = 0, n_pre = 0, n_stb = 0, n_post = 0, total = 0;
    int   err_addr = 0, err_bus = 0, err_ovl = 0;
    logic [7:0] last_rd = '0;
    cur = '0;
    forever begin
      @(negedge clk);
      bus_in = 8'hC3;
      if (!rst) begin
        if (!in_acc && ale) begin
          if (sb_q.size() == 0) begin
            check("R10", "unrequested ALE", 1, 0);
          end else begin
            cur = sb_q[0];
            in_acc = 1; seen_stb = 0;
            n_ale = 0; n_addr = 0; n_pre = 0; n_stb = 0; n_post = 0; total = 0;
            err_addr = 0; err_bus = 0; err_ovl = 0;
          end
        end
        if (!in_acc && done) check("R7", "done outside access", 1, 0);
        if (in_acc) begin
          if (done) begin
            check("R2",  "ALE clocks", n_ale, 1);
            check("R2",  "address errors", err_addr, 0);
            check("R3",  "address hold clocks", n_addr, int'(cur.n_addr));
            check("R4",  "data setup clocks", n_pre, int'(cur.n_pre));
            check("R5",  "strobe clocks", n_stb, int'(cur.n_stb));
            check("R6",  "hold clocks", n_post, int'(cur.n_post));
            check("R7",  "total clocks", total, int'(cur.total));
            check("R9",  "bus drive errors", err_bus, 0);
            check("R12", "strobe overlap errors", err_ovl, 0);
            if (!cur.wr) last_rd = cur.rdx;
            check("R8",  "rd_data", int'(rd_data), int'(last_rd));
            void'(sb_q.pop_front());
            in_acc = 0;
          end else begin
            total++;
            if (addr_hi != cur.addr[15:8]) err_addr++;
            if ((!rd_n && !wr_n) || (ale && (!rd_n || !wr_n))) err_ovl++;
            if (ale) begin
              n_ale++;
              if (!(bus_oe && bus_out == cur.addr[7:0])) err_addr++;
            end else if (!rd_n || !wr_n) begin
              n_stb++;
              seen_stb = 1;
              if (cur.wr ? wr_n : rd_n) err_ovl++;
              if (cur.wr) begin
                if (!(bus_oe && bus_out == cur.wdata)) err_bus++;
              end else begin
                if (bus_oe) err_bus++;
                bus_in = cur.seed + 8'(n_stb - 1);
              end
            end else if (!seen_stb) begin
              if (bus_oe && bus_out == cur.addr[7:0]) begin
                n_addr++;
              end else begin
                n_pre++;
                if (cur.wr ? !(bus_oe && bus_out == cur.wdata) : bus_oe) err_bus++;
              end
            end else begin
              n_post++;
              if (cur.wr ? !(bus_oe && bus_out == cur.wdata) : bus_oe) err_bus++;
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog", "run finished", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    check("R1", "ale", int'(ale), 0);
    check("R1", "rd_n", int'(rd_n), 1);
    check("R1", "wr_n", int'(wr_n), 1);
    check("R1", "bus_oe", int'(bus_oe), 0);
    check("R1", "addr_hi", int'(addr_hi), 0);
    check("R1", "done", int'(done), 0);
    for (int c = 0; c < 8; c++) begin
      logic [15:0] a;
      a = 16'h1234 + 16'(c * 16'h0111);
      run_access(1'b0, c, a, 8'h00, 8'(8'h20 + c * 8'h11), (c % 3) == 1);
      run_access(1'b1, c, ~a, a[7:0], 8'h00, (c % 3) == 0);
    end
    run_access(1'b0, 7, 16'hFFFF, 8'h00, 8'hF0, 1'b0);
    run_access(1'b1, 4, 16'h0000, 8'hFF, 8'h00, 1'b1);
    // R1: back to idle after the last access
    check("R1", "idle ale", int'(ale), 0);
    check("R1", "idle bus_oe", int'(bus_oe), 0);
    check("R1", "idle addr_hi", int'(addr_hi), 0);
    check("R10", "pending accesses", sb_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule